// File: doc/BRIEF.md
# Pulse Duty Capture and Source Selector

This block turns a slow pulse-width speed command into an 8-bit internal duty request. It measures the high time and the period of an already synchronized pulse input, forms a duty code on every rising edge of the filtered signal, and decides whether that code or an 8-bit code from an analog converter drives the request. Once a source is chosen, its code passes through an end-point correction. The correction has dead bands at both ends and a linear stretch in between.

The pulse measurement is protected in four ways. A glitch filter removes short spikes. Periods that are too fast are thrown away. A level that never changes is timed out to a full-off or full-on reading. A hysteresis band keeps the source choice from chattering near either end of the range. A disable input and a one-cycle fault-clear strobe both wipe the measured data and force the request to zero. Each of them also starts a hold-off window. During that window no new measurement is accepted and the request stays at zero.

All limits are in clock cycles of the reference clock, and each one is a parameter. The defaults suit a 5.12 MHz clock.

Top module: `pwm_duty_select`

## Requirements
- R1: A level change on `pwm_in` is taken only after it has persisted for more than `FILT_CYC` consecutive cycles. A pulse of `FILT_CYC` cycles or fewer has no effect on the measured period or high time.
- R2: At each accepted filtered rising edge that closes a full period, the measured code becomes floor(high_cycles*255/period_cycles). When the pulse source is selected, the request is the corrected measured code.
- R3: Source selection uses hysteresis on the measured code. While the analog code is selected, the pulse source is taken when the measured code is in 15..240. While the pulse source is selected, the analog code is taken when the measured code is 10 or less, or 245 or more. For measured codes 11..14 and 241..244, the previous source is kept. The selection changes only when a new measurement arrives or during hold.
- R4: If the filtered input stays low for `TO_CYC` cycles, the measured code becomes 0. If it stays high for `TO_CYC` cycles, the measured code becomes 255. In either case the analog code is selected.
- R5: A period shorter than `MIN_PER` cycles is discarded and the previously held measured code is kept. The first rising edge after a clear, a hold-off or a timeout only starts a period.
- R6: Correction of a selected code x: x of 38 or less gives 0, x of 217 or more gives 255, and anything in between gives floor((x-38)*255/179). Both sources use the same correction.
- R7: During reset, `duty_out` is 0, `src_pulse` is 0 and `duty_vld` is 0. After reset the measured code is 0, so the analog code drives the request, one clock after it is sampled.
- R8: While `dis` is high, `duty_out`, `src_pulse` and `duty_vld` are 0 from the next clock, and the measured data are cleared. For `BLANK_CYC` clocks after `dis` falls, no measurement is taken and `duty_out` stays 0.
- R9: A one-cycle `flt_clr` has the same effect as a one-cycle disable: the output goes to 0, the measured code is cleared, and the hold-off window restarts. A `flt_clr` in the same cycle as an incoming measurement wins over that measurement.
- R10: `duty_vld` is a single-cycle pulse, issued once for each accepted measurement or timeout. It is high in the same cycle that `duty_out` first shows the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Synchronized pulse-width command |
| adc_code | input | 8 | Analog-derived duty code, 0..255 |
| dis | input | 1 | Active-high disable |
| flt_clr | input | 1 | One-cycle fault-clear strobe |
| duty_out | output | 8 | Corrected internal duty request, 0..255 |
| src_pulse | output | 1 | 1 when the measured pulse duty is the source, 0 for the analog code |
| duty_vld | output | 1 | One-cycle pulse marking a new measurement result |

## Verification
A fault-clear strobe and a completed period measurement can fall in the same clock: the clear arrives just as the filtered rising edge closes a valid period. To provoke this, the bench drives a rising edge exactly one full valid period after the previous one. It then counts the filter latency in clocks and raises `flt_clr` so that it is sampled on the same edge where the measurement would register. The collision is judged correct if no `duty_vld` pulse appears afterwards, `duty_out` drops to 0, and the analog source is reported, which shows that the clear overrode the sample.

// File: rtl/pwm_sel_pkg.sv
package pwm_sel_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_FULL = '1;

  typedef enum logic {
    SRC_ANALOG = 1'b0,
    SRC_PULSE  = 1'b1
  } duty_src_e;
endpackage

// File: rtl/pwm_glitch_filter.sv
module pwm_glitch_filter #(
  parameter int unsigned FILT_CYC = 51
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] FILT_LIM = CW'(FILT_CYC);

  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // a differing level must be seen FILT_CYC+1 times in a row
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (raw_i != filt_q) begin
      if (cnt_q == FILT_LIM) begin
        filt_d = raw_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  // R1
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(raw_i)));
endmodule

// File: rtl/pwm_period_meter.sv
module pwm_period_meter import pwm_sel_pkg::*; #(
  parameter int unsigned MIN_PER = 4096,
  parameter int unsigned TO_CYC  = 1049600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              filt_i,
  output logic [CODE_W-1:0] meas_o,
  output logic              upd_o
);
  localparam int unsigned CNT_W = $clog2(TO_CYC + 1);
  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TO_CYC);

  logic              lvl_prev_q, armed_q, armed_d, upd_q, upd_d;
  logic [CNT_W-1:0]  per_q, per_d, hi_q, hi_d, lvl_q, lvl_d;
  logic [CODE_W-1:0] meas_q, meas_d;
  logic              rise, chg, to_hit;
  logic [CNT_W+7:0]  hi_x255;

  assign rise    = filt_i & ~lvl_prev_q;
  assign chg     = filt_i ^ lvl_prev_q;
  assign to_hit  = !chg && (lvl_q == TO_LIM - 1'b1);
  assign hi_x255 = {hi_q, 8'd0} - {8'd0, hi_q};

  always_comb begin
    armed_d = armed_q;
    per_d   = per_q;
    hi_d    = hi_q;
    lvl_d   = lvl_q;
    meas_d  = meas_q;
    upd_d   = 1'b0;
    if (clr_i) begin
      armed_d = 1'b0;
      per_d   = '0;
      hi_d    = '0;
      lvl_d   = '0;
      meas_d  = '0;
    end else begin
      per_d = (per_q == '1) ? per_q : per_q + 1'b1;
      if (filt_i && hi_q != '1) hi_d = hi_q + 1'b1;
      if (chg)                  lvl_d = CNT_W'(1);
      else if (lvl_q != TO_LIM) lvl_d = lvl_q + 1'b1;
      if (rise) begin
        per_d   = CNT_W'(1);
        hi_d    = CNT_W'(1);
        armed_d = 1'b1;
        if (armed_q && per_q >= MIN_LIM) begin
          meas_d = CODE_W'(hi_x255 / {8'd0, per_q});
          upd_d  = 1'b1;
        end
      end else if (to_hit) begin
        meas_d  = filt_i ? CODE_FULL : '0;
        upd_d   = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      per_q      <= '0;
      hi_q       <= '0;
      lvl_q      <= '0;
      meas_q     <= '0;
      upd_q      <= 1'b0;
    end else begin
      lvl_prev_q <= filt_i;
      armed_q    <= armed_d;
      per_q      <= per_d;
      hi_q       <= hi_d;
      lvl_q      <= lvl_d;
      meas_q     <= meas_d;
      upd_q      <= upd_d;
    end
  end

  assign meas_o = meas_q;
  assign upd_o  = upd_q;

  // R5
  short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr_i && per_q < MIN_LIM) |=> (!upd_q && $stable(meas_q)));
endmodule

// File: rtl/duty_end_map.sv
module duty_end_map import pwm_sel_pkg::*; #(
  parameter int unsigned CORR_LO = 38,
  parameter int unsigned CORR_HI = 217
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] LO_C = CODE_W'(CORR_LO);
  localparam logic [CODE_W-1:0] HI_C = CODE_W'(CORR_HI);
  localparam logic [15:0]       SPAN = 16'(CORR_HI - CORR_LO);

  logic [15:0] prod;

  always_comb begin
    prod = (16'(code_i) - 16'(LO_C)) * 16'd255;
    if (code_i <= LO_C)      code_o = '0;
    else if (code_i >= HI_C) code_o = CODE_FULL;
    else                     code_o = CODE_W'(prod / SPAN);
  end
endmodule

// File: rtl/pwm_duty_select.sv
module pwm_duty_select import pwm_sel_pkg::*; #(
  parameter int unsigned FILT_CYC   = 51,
  parameter int unsigned MIN_PER    = 4096,
  parameter int unsigned TO_CYC     = 1049600,
  parameter int unsigned BLANK_CYC  = 51200,
  parameter int unsigned SEL_LO_IN  = 15,
  parameter int unsigned SEL_LO_OUT = 10,
  parameter int unsigned SEL_HI_IN  = 240,
  parameter int unsigned SEL_HI_OUT = 245,
  parameter int unsigned CORR_LO    = 38,
  parameter int unsigned CORR_HI    = 217
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [CODE_W-1:0] adc_code,
  input  logic              dis,
  input  logic              flt_clr,
  output logic [CODE_W-1:0] duty_out,
  output logic              src_pulse,
  output logic              duty_vld
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0]     BLANK_LIM = BW'(BLANK_CYC);
  localparam logic [CODE_W-1:0] LO_IN_C   = CODE_W'(SEL_LO_IN);
  localparam logic [CODE_W-1:0] LO_OUT_C  = CODE_W'(SEL_LO_OUT);
  localparam logic [CODE_W-1:0] HI_IN_C   = CODE_W'(SEL_HI_IN);
  localparam logic [CODE_W-1:0] HI_OUT_C  = CODE_W'(SEL_HI_OUT);

  logic              filt, meas_upd, hold;
  logic [CODE_W-1:0] meas, sel_code, mapped, duty_q, duty_d;
  logic [BW-1:0]     blank_q, blank_d;
  duty_src_e         src_q, src_d;
  logic              vld_q, vld_d;

  pwm_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(pwm_in), .filt_o(filt));

  pwm_period_meter #(.MIN_PER(MIN_PER), .TO_CYC(TO_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .clr_i(hold), .filt_i(filt),
    .meas_o(meas), .upd_o(meas_upd));

  duty_end_map #(.CORR_LO(CORR_LO), .CORR_HI(CORR_HI)) u_map (
    .code_i(sel_code), .code_o(mapped));

  assign hold = dis | flt_clr | (blank_q != '0);

  always_comb begin
    blank_d = blank_q;
    if (dis || flt_clr)     blank_d = BLANK_LIM;
    else if (blank_q != '0) blank_d = blank_q - 1'b1;
  end

  always_comb begin
    src_d = src_q;
    if (hold) begin
      src_d = SRC_ANALOG;
    end else if (src_q == SRC_ANALOG) begin
      if (meas >= LO_IN_C && meas <= HI_IN_C) src_d = SRC_PULSE;
    end else begin
      if (meas <= LO_OUT_C || meas >= HI_OUT_C) src_d = SRC_ANALOG;
    end
    sel_code = (src_d == SRC_PULSE) ? meas : adc_code;
    duty_d   = hold ? '0 : mapped;
    vld_d    = !hold && meas_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
      src_q   <= SRC_ANALOG;
      duty_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      blank_q <= blank_d;
      src_q   <= src_d;
      duty_q  <= duty_d;
      vld_q   <= vld_d;
    end
  end

  assign duty_out  = duty_q;
  assign src_pulse = (src_q == SRC_PULSE);
  assign duty_vld  = vld_q;

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (duty_out == '0 && !duty_vld && !src_pulse));

  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld |=> !duty_vld);

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !meas_upd) |=> $stable(src_q));
endmodule

// File: tb/sim_pwm_duty_select.sv
module sim_pwm_duty_select;
  localparam int FILT = 4;
  localparam int MINP = 40;
  localparam int TOC  = 600;
  localparam int BLK  = 50;

  // period, high, adc code, expected source
  localparam int VEC [8][4] = '{
    '{200, 100,  90, 1},
    '{200,  10,  90, 1},
    '{200,   6, 128, 0},
    '{200,  10, 200, 0},
    '{200, 180, 200, 1},
    '{200, 190, 200, 1},
    '{200, 194,  20, 0},
    '{200, 120,  20, 1}
  };

  logic       clk, rst_n, pwm_in, dis, flt_clr;
  logic [7:0] adc_code, duty_out;
  logic       src_pulse, duty_vld;
  int         n_chk, n_fail, vld_cnt, vld_dbl;
  logic       vld_prev;

  pwm_duty_select #(.FILT_CYC(FILT), .MIN_PER(MINP), .TO_CYC(TOC),
                    .BLANK_CYC(BLK)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .adc_code(adc_code),
    .dis(dis), .flt_clr(flt_clr), .duty_out(duty_out),
    .src_pulse(src_pulse), .duty_vld(duty_vld));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    vld_cnt = 0; vld_dbl = 0; vld_prev = 1'b0;
  end
  always @(negedge clk) begin
    if (duty_vld) vld_cnt++;
    if (duty_vld && vld_prev) vld_dbl++;
    vld_prev = duty_vld;
  end

  function automatic int ref_map(input int x);
    if (x <= 38) return 0;
    if (x >= 217) return 255;
    return ((x - 38) * 255) / 179;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_pwm(input int p, input int h, input int n);
    for (int k = 0; k < n; k++) begin
      pwm_in = 1'b1;
      repeat (h) @(negedge clk);
      pwm_in = 1'b0;
      repeat (p - h) @(negedge clk);
    end
  endtask

  task automatic run_glitch(input int n);
    for (int k = 0; k < n; k++) begin
      pwm_in = 1'b1; repeat (100) @(negedge clk);
      pwm_in = 1'b0; repeat (30) @(negedge clk);
      pwm_in = 1'b1; repeat (FILT) @(negedge clk);
      pwm_in = 1'b0; repeat (70 - FILT) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; pwm_in = 1'b0; dis = 1'b0; flt_clr = 1'b0; adc_code = 8'd100;
    repeat (3) @(negedge clk);
    chk("R7 reset duty", duty_out, 0);
    chk("R7 reset src", src_pulse, 0);
    chk("R7 reset vld", duty_vld, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 analog priority after reset", duty_out, ref_map(100));

    // vector table: R2 R3 R6
    for (int i = 0; i < 8; i++) begin
      adc_code = 8'(VEC[i][2]);
      run_pwm(VEC[i][0], VEC[i][1], 3);
      chk("R3 source", src_pulse, VEC[i][3]);
      if (VEC[i][3] == 1)
        chk("R2 measured duty", duty_out, ref_map(VEC[i][1] * 255 / VEC[i][0]));
      else
        chk("R6 analog duty", duty_out, ref_map(VEC[i][2]));
    end

    // R10 one pulse per measured period
    vld_cnt = 0; vld_dbl = 0;
    run_pwm(200, 120, 5);
    repeat (10) @(negedge clk);
    chk("R10 valid count", vld_cnt, 5);
    chk("R10 valid width", vld_dbl, 0);

    // R1 glitch of FILT cycles in low phase
    run_glitch(3);
    chk("R1 glitch ignored", duty_out, ref_map(100 * 255 / 200));

    // R5 too-fast period discarded
    run_pwm(30, 10, 6);
    chk("R5 fast period kept duty", duty_out, ref_map(100 * 255 / 200));
    chk("R5 fast period kept src", src_pulse, 1);

    // R4 stuck low then stuck high
    adc_code = 8'd60;
    pwm_in = 1'b0;
    repeat (300) @(negedge clk);
    chk("R4 before timeout", src_pulse, 1);
    repeat (400) @(negedge clk);
    chk("R4 low timeout src", src_pulse, 0);
    chk("R4 low timeout duty", duty_out, ref_map(60));
    run_pwm(200, 100, 3);
    chk("R4 remeasure", src_pulse, 1);
    pwm_in = 1'b1;
    repeat (700) @(negedge clk);
    chk("R4 high timeout src", src_pulse, 0);
    chk("R4 high timeout duty", duty_out, ref_map(60));

    // R6 end points through analog path
    adc_code = 8'd38;  @(negedge clk); chk("R6 x=38", duty_out, 0);
    adc_code = 8'd39;  @(negedge clk); chk("R6 x=39", duty_out, 1);
    adc_code = 8'd216; @(negedge clk); chk("R6 x=216", duty_out, 253);
    adc_code = 8'd217; @(negedge clk); chk("R6 x=217", duty_out, 255);
    adc_code = 8'd255; @(negedge clk); chk("R6 x=255", duty_out, 255);
    adc_code = 8'd0;   @(negedge clk); chk("R6 x=0", duty_out, 0);
    adc_code = 8'd60;
    pwm_in = 1'b0;
    repeat (20) @(negedge clk);

    // R8 disable and hold-off window
    run_pwm(200, 100, 3);
    chk("R8 pre-disable src", src_pulse, 1);
    dis = 1'b1;
    @(negedge clk);
    chk("R8 disable duty", duty_out, 0);
    chk("R8 disable src", src_pulse, 0);
    vld_cnt = 0;
    run_pwm(200, 100, 2);
    chk("R8 no valid while disabled", vld_cnt, 0);
    dis = 1'b0;
    fork
      run_pwm(200, 100, 3);
      begin
        repeat (40) @(negedge clk);
        chk("R8 hold-off duty", duty_out, 0);
        repeat (260) @(negedge clk);
        chk("R8 hold-off blocked edge src", src_pulse, 0);
        chk("R8 hold-off analog duty", duty_out, ref_map(60));
      end
    join
    chk("R8 remeasure src", src_pulse, 1);
    chk("R8 remeasure duty", duty_out, ref_map(127));

    // R9 fault clear
    flt_clr = 1'b1;
    @(negedge clk);
    flt_clr = 1'b0;
    chk("R9 clear duty", duty_out, 0);
    chk("R9 clear src", src_pulse, 0);
    repeat (60) @(negedge clk);
    chk("R9 data cleared src", src_pulse, 0);
    chk("R9 data cleared duty", duty_out, ref_map(60));
    run_pwm(200, 100, 3);
    chk("R9 remeasure", src_pulse, 1);

    // R9 clear landing on the measurement edge
    vld_cnt = 0;
    pwm_in = 1'b1;
    repeat (FILT + 1) @(negedge clk);
    flt_clr = 1'b1;
    @(negedge clk);
    flt_clr = 1'b0;
    chk("R9 collision duty", duty_out, 0);
    chk("R9 collision src", src_pulse, 0);
    repeat (20) @(negedge clk);
    chk("R9 collision no valid", vld_cnt, 0);
    pwm_in = 1'b0;
    repeat (10) @(negedge clk);

    finish_run();
  end
endmodule